// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous fast-page-mode DRAM array alive. It runs on a fixed system clock and drives the active-low row strobe, column strobe and write enable. After reset it first waits out the power-up delay. It then runs a burst of warm-up refresh cycles on its own. Once those have finished it raises `ready`, and from then on normal accesses may begin.

In normal operation a free-running interval counter produces one refresh credit for every row period. The row period is the refresh period divided by the row count, rounded down. Each refresh is a column-before-row cycle that uses the memory's internal row counter, so the sequencer never drives an address. Every refresh in normal operation is negotiated with the access controller. The sequencer holds `req` until the controller answers with `grant`, and `busy` marks the strobe activity so that the controller keeps the bus free. Credits queue up to a limit. When the queue is full, `req_urgent` tells the controller to yield.

All strobe timings are given in nanoseconds. They are turned into clock counts at elaboration by ceiling division by `CLK_PERIOD_NS`. A parameter selects between the normal refresh period and the long refresh period of the low-power variant.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, ras_n, cas_n and we_n are 1 and req, req_urgent, busy and ready are 0.
- R2: After reset is released, cas_n and ras_n stay 1 for at least ceil(POWERUP_NS/CLK_PERIOD_NS) cycles.
- R3: After the power-up wait, exactly INIT_CYCLES refresh cycles are issued with no request. ready rises only after the last of them, and req and req_urgent stay 0 while ready is 0.
- R4: In every refresh cycle cas_n is already 0 in the cycle before ras_n falls.
- R5: ras_n stays 0 for exactly RAS_CYC cycles, where RAS_CYC = max(ceil(tRAS), ceil(tCHR)) in clocks, and cas_n is 0 for that whole time.
- R6: ras_n stays high for at least ceil(tRP) cycles between two cycles, and two falls of ras_n are at least ceil(tRC) cycles apart.
- R7: we_n is never driven to 0, so no refresh cycle can be taken as test-mode entry.
- R8: Once ready is 1, one refresh credit is added every INT_CYC = floor(period/ROWS/CLK_PERIOD_NS) cycles. While credits remain and no cycle is running, req is 1, and it stays 1 until grant is sampled.
- R9: Once ready is 1, a refresh cycle starts only on a clock edge at which req and grant are both 1. cas_n is 0 in the very next cycle.
- R10: Credits saturate at MAX_PENDING, and further ticks are dropped. req_urgent is 1 while the count is at the limit, and each granted cycle removes one credit.
- R11: LOW_POWER=1 selects REF_LOWPWR_NS instead of REF_NORMAL_NS as the refresh period, which changes the spacing of refreshes when grant is held.
- R12: busy is 1 from the first cycle in which cas_n is 0 until the end of the precharge, and it is 0 when no refresh cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant | input | 1 | Access controller yields the array for one refresh |
| req | output | 1 | Refresh wanted, held until granted |
| req_urgent | output | 1 | Credit queue is full |
| ready | output | 1 | Power-up and warm-up finished, normal access allowed |
| busy | output | 1 | Refresh strobe sequence in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The bench keeps the 10 ns clock and the default strobe timings, so one refresh spans 11 clocks. It shortens the power-up delay to 2 µs and the normal refresh period to 1.024 ms, which gives a 100-cycle credit interval. Within a few thousand cycles it can therefore cover the warm-up burst, withheld grants, a full credit queue with ticks being dropped, and a granted drain. A second instance is built with LOW_POWER=1 and a period of 8.192 ms, and its 800-cycle spacing is compared with the 100-cycle spacing of the first.

// File: rtl/dram_ref_pkg.sv
// Package: shared state types and elaboration-time helpers for the
// refresh sequencer. Assumes all timing inputs are non-negative ns values.
package dram_ref_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_CAS,
        CYC_RAS,
        CYC_PRE
    } cyc_state_t;

    typedef enum logic [1:0] {
        SEQ_POWERUP,
        SEQ_WARMUP,
        SEQ_RUN
    } seq_state_t;

    // Ceiling conversion of a nanosecond value to whole clocks.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Subtraction clamped at zero.
    function automatic int unsigned sub_sat(int unsigned a, int unsigned b);
        return (a > b) ? a - b : 0;
    endfunction

endpackage

// File: rtl/dram_ref_cycle.sv
// Module: runs one column-before-row refresh cycle per start pulse.
// Phases: column strobe lead, row strobe low (column held low), precharge.
// Assumes start is only asserted while idle is high.
module dram_ref_cycle
    import dram_ref_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 1,
    parameter int unsigned LOW_CYC  = 6,
    parameter int unsigned PRE_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic done,
    output logic busy,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    localparam int unsigned MAX_PH = max_u(max_u(LEAD_CYC, LOW_CYC), PRE_CYC);
    localparam int unsigned CW     = $clog2(MAX_PH + 1);

    cyc_state_t    state;
    logic [CW-1:0] ph_cnt;
    logic          ph_last;

    // Terminal count of the current phase.
    always_comb begin
        case (state)
            CYC_CAS: ph_last = (ph_cnt == CW'(LEAD_CYC - 1));
            CYC_RAS: ph_last = (ph_cnt == CW'(LOW_CYC - 1));
            CYC_PRE: ph_last = (ph_cnt == CW'(PRE_CYC - 1));
            default: ph_last = 1'b0;
        endcase
    end

    // Phase sequencing and per-phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CYC_IDLE;
            ph_cnt <= '0;
        end else begin
            case (state)
                CYC_IDLE: begin
                    ph_cnt <= '0;
                    if (start) state <= CYC_CAS;
                end
                CYC_CAS: begin
                    ph_cnt <= ph_last ? '0 : ph_cnt + 1'b1;
                    if (ph_last) state <= CYC_RAS;
                end
                CYC_RAS: begin
                    ph_cnt <= ph_last ? '0 : ph_cnt + 1'b1;
                    if (ph_last) state <= CYC_PRE;
                end
                default: begin
                    ph_cnt <= ph_last ? '0 : ph_cnt + 1'b1;
                    if (ph_last) state <= CYC_IDLE;
                end
            endcase
        end
    end

    // Strobe decode; write enable stays high to keep out of test mode.
    always_comb begin
        idle  = (state == CYC_IDLE);
        busy  = (state != CYC_IDLE);
        done  = (state == CYC_PRE) && ph_last;
        ras_n = (state != CYC_RAS);
        cas_n = !((state == CYC_CAS) || (state == CYC_RAS));
        we_n  = 1'b1;
    end

endmodule

// File: rtl/dram_ref_timer.sv
// Module: free-running row-interval counter and refresh credit queue.
// Credits accrue only while enable is high; the count saturates at the limit.
module dram_ref_timer #(
    parameter int unsigned INT_CYC     = 100,
    parameter int unsigned MAX_PENDING = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic take,
    output logic pending_nz,
    output logic pending_full
);

    localparam int unsigned IW = $clog2(INT_CYC + 1);
    localparam int unsigned PW = $clog2(MAX_PENDING + 1);

    logic [IW-1:0] int_cnt;
    logic [PW-1:0] pend;
    logic          tick;
    logic          add;
    logic          sub;

    assign tick = (int_cnt == IW'(INT_CYC - 1));
    assign add  = tick && enable && (pend != PW'(MAX_PENDING));
    assign sub  = take && (pend != '0);

    // Row-interval counter, wraps every INT_CYC clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)    int_cnt <= '0;
        else if (tick) int_cnt <= '0;
        else           int_cnt <= int_cnt + 1'b1;
    end

    // Credit count: add on tick, remove on accepted refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= '0;
        else if (add && !sub) pend <= pend + 1'b1;
        else if (sub && !add) pend <= pend - 1'b1;
    end

    assign pending_nz   = (pend != '0);
    assign pending_full = (pend == PW'(MAX_PENDING));

endmodule

// File: rtl/dram_ref_init.sv
// Module: power-up wait followed by the warm-up refresh burst.
// Assumes cyc_done pulses once at the end of every refresh cycle.
module dram_ref_init
    import dram_ref_pkg::*;
#(
    parameter int unsigned PWR_CYC     = 200,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_idle,
    input  logic cyc_done,
    output logic init_start,
    output logic ready
);

    localparam int unsigned WW = $clog2(PWR_CYC + 1);
    localparam int unsigned DW = $clog2(INIT_CYCLES + 1);

    seq_state_t    state;
    logic [WW-1:0] wait_cnt;
    logic [DW-1:0] done_cnt;

    // Bring-up state machine: wait, warm up, then run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_POWERUP;
            wait_cnt <= '0;
            done_cnt <= '0;
        end else begin
            case (state)
                SEQ_POWERUP: begin
                    if (wait_cnt == WW'(PWR_CYC - 1)) state <= SEQ_WARMUP;
                    else                              wait_cnt <= wait_cnt + 1'b1;
                end
                SEQ_WARMUP: begin
                    if (cyc_done) begin
                        if (done_cnt == DW'(INIT_CYCLES - 1)) state <= SEQ_RUN;
                        else                                   done_cnt <= done_cnt + 1'b1;
                    end
                end
                default: state <= SEQ_RUN;
            endcase
        end
    end

    assign init_start = (state == SEQ_WARMUP) && cyc_idle;
    assign ready      = (state == SEQ_RUN);

endmodule

// File: rtl/dram_refresh_seq.sv
// Top: refresh and initialization sequencer for a fast-page-mode DRAM array.
// Converts ns timing to clocks, runs bring-up, then issues granted
// column-before-row refreshes at the per-row interval.
// Assumes the controller keeps the array idle while busy is high.
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned ROWS          = 1024,
    parameter bit          LOW_POWER     = 1'b0,
    parameter int unsigned REF_NORMAL_NS = 16_000_000,
    parameter int unsigned REF_LOWPWR_NS = 128_000_000,
    parameter int unsigned POWERUP_NS    = 200_000,
    parameter int unsigned INIT_CYCLES   = 8,
    parameter int unsigned MAX_PENDING   = 8,
    parameter int unsigned T_CSR_NS      = 5,
    parameter int unsigned T_CHR_NS      = 10,
    parameter int unsigned T_RAS_NS      = 60,
    parameter int unsigned T_RP_NS       = 40,
    parameter int unsigned T_RC_NS       = 110,
    parameter int unsigned T_RPC_NS      = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic req,
    output logic req_urgent,
    output logic ready,
    output logic busy,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    localparam int unsigned REF_NS   = LOW_POWER ? REF_LOWPWR_NS : REF_NORMAL_NS;
    localparam int unsigned INT_CYC  = max_u(REF_NS / ROWS / CLK_PERIOD_NS, 1);
    localparam int unsigned PWR_CYC  = max_u(ns_to_cyc(POWERUP_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned CSR_CYC  = max_u(ns_to_cyc(T_CSR_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned RAS_CYC  = max_u(max_u(ns_to_cyc(T_RAS_NS, CLK_PERIOD_NS),
                                                   ns_to_cyc(T_CHR_NS, CLK_PERIOD_NS)), 1);
    localparam int unsigned RP_CYC   = ns_to_cyc(T_RP_NS, CLK_PERIOD_NS);
    localparam int unsigned RC_CYC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned RPC_CYC  = ns_to_cyc(T_RPC_NS, CLK_PERIOD_NS);
    localparam int unsigned PRE_CYC  = max_u(max_u(sub_sat(RP_CYC, CSR_CYC),
                                                   sub_sat(RC_CYC, RAS_CYC + CSR_CYC)),
                                             max_u(RPC_CYC, 1));

    logic cyc_idle;
    logic cyc_done;
    logic cyc_start;
    logic init_start;
    logic pend_nz;
    logic pend_full;
    logic run_take;

    dram_ref_init #(
        .PWR_CYC    (PWR_CYC),
        .INIT_CYCLES(INIT_CYCLES)
    ) init_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_idle  (cyc_idle),
        .cyc_done  (cyc_done),
        .init_start(init_start),
        .ready     (ready)
    );

    dram_ref_timer #(
        .INT_CYC    (INT_CYC),
        .MAX_PENDING(MAX_PENDING)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ready),
        .take        (run_take),
        .pending_nz  (pend_nz),
        .pending_full(pend_full)
    );

    dram_ref_cycle #(
        .LEAD_CYC(CSR_CYC),
        .LOW_CYC (RAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) cycle_i (
        .clk  (clk),
        .rst_n(rst_n),
        .start(cyc_start),
        .idle (cyc_idle),
        .done (cyc_done),
        .busy (busy),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n)
    );

    // Request handshake: ask while credits remain and the strobes are free.
    always_comb begin
        req        = ready && pend_nz && cyc_idle;
        req_urgent = ready && pend_full;
        run_take   = req && grant;
        cyc_start  = init_start || run_take;
    end

endmodule

// File: rtl/dram_refresh_seq_chk.sv
// Checker: temporal rules on the sequencer ports, bound to the top.
// Assumes RP_MIN and RAS_LEN match the top's derived clock counts.
module dram_refresh_seq_chk #(
    parameter int unsigned RP_MIN  = 4,
    parameter int unsigned RAS_LEN = 6
) (
    input logic clk,
    input logic rst_n,
    input logic grant,
    input logic req,
    input logic req_urgent,
    input logic ready,
    input logic busy,
    input logic ras_n,
    input logic cas_n
);

    localparam int unsigned HW = $clog2(RP_MIN + RAS_LEN + 2);

    logic [HW-1:0] hi_cnt;
    logic [HW-1:0] lo_cnt;

    // Run lengths of the row strobe high and low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= HW'(RP_MIN);
            lo_cnt <= '0;
        end else if (ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R4
    cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R5
    cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_cnt == HW'(RAS_LEN)));

    // R6
    ras_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= HW'(RP_MIN)));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant) |=> req);

    // R9
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $fell(cas_n)) |-> $past(req && grant));

    // R3
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!req && !req_urgent));

    // R12
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> busy);

    // R10
    urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_urgent && !busy) |-> req);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .RP_MIN (RP_CYC),
    .RAS_LEN(RAS_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .req       (req),
    .req_urgent(req_urgent),
    .ready     (ready),
    .busy      (busy),
    .ras_n     (ras_n),
    .cas_n     (cas_n)
);

// File: tb/dram_refresh_seq_tb.sv
// Bench: directed scenarios, one task each, checking at falling edges.
module dram_refresh_seq_tb_top;

    localparam int CLK_NS   = 10;
    localparam int PWR_CYC  = 200;
    localparam int INT_N    = 100;
    localparam int INT_LP   = 800;
    localparam int INIT_N   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0;
    logic req, req_urgent, ready, busy, ras_n, cas_n, we_n;
    logic lp_req, lp_urg, lp_ready, lp_busy, lp_ras_n, lp_cas_n, lp_we_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS / 2) clk = ~clk;

    dram_refresh_seq #(
        .CLK_PERIOD_NS(CLK_NS),
        .REF_NORMAL_NS(1_024_000),
        .POWERUP_NS   (2_000)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .grant(grant), .req(req),
        .req_urgent(req_urgent), .ready(ready), .busy(busy),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    dram_refresh_seq #(
        .CLK_PERIOD_NS(CLK_NS),
        .LOW_POWER    (1'b1),
        .REF_NORMAL_NS(1_024_000),
        .REF_LOWPWR_NS(8_192_000),
        .POWERUP_NS   (2_000)
    ) dut_lp_i (
        .clk(clk), .rst_n(rst_n), .grant(1'b1), .req(lp_req),
        .req_urgent(lp_urg), .ready(lp_ready), .busy(lp_busy),
        .ras_n(lp_ras_n), .cas_n(lp_cas_n), .we_n(lp_we_n)
    );

    // Strobe monitor statistics for the normal instance.
    int cyc = 0, first_cas = -1, falls = 0, falls_pre = 0;
    int last_fall = -1, last_rise = 0, spacing = 0;
    int min_low = 9999, min_f2f = 9999, min_high = 9999;
    int lead_bad = 0, overlap_bad = 0, we_bad = 0, req_early = 0;
    logic p_ras = 1'b1, p_cas = 1'b1;
    int lp_falls = 0, lp_last = -1, lp_spacing = 0;
    logic lp_p_ras = 1'b1;

    // Sample both instances away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_cas && !cas_n && first_cas < 0) first_cas = cyc;
            if (p_ras && !ras_n) begin
                falls++;
                if (!ready) falls_pre++;
                if (p_cas) lead_bad++;
                if (last_fall >= 0) begin
                    spacing = cyc - last_fall;
                    if (spacing < min_f2f) min_f2f = spacing;
                    if (cyc - last_rise < min_high) min_high = cyc - last_rise;
                end
                last_fall = cyc;
            end
            if (!p_ras && ras_n) begin
                last_rise = cyc;
                if (cyc - last_fall < min_low) min_low = cyc - last_fall;
            end
            if (!ras_n && cas_n) overlap_bad++;
            if (!we_n || !lp_we_n) we_bad++;
            if ((req || req_urgent) && !ready) req_early++;
            if (lp_p_ras && !lp_ras_n) begin
                lp_falls++;
                if (lp_last >= 0) lp_spacing = cyc - lp_last;
                lp_last = cyc;
            end
            p_ras = ras_n;
            p_cas = cas_n;
            lp_p_ras = lp_ras_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        check(!req && !req_urgent, "R1 no request in reset", {req, req_urgent}, 0);
        check(!busy && !ready, "R1 idle in reset", {busy, ready}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_bringup();
        for (int k = 0; k < 2000 && !ready; k++) @(negedge clk);
        check(ready == 1'b1, "R3 ready reached", ready, 1);
        check(first_cas >= PWR_CYC, "R2 power-up wait", first_cas, PWR_CYC);
        check(falls_pre == INIT_N, "R3 warm-up cycle count", falls_pre, INIT_N);
        check(req_early == 0, "R3 no request before ready", req_early, 0);
    endtask

    task automatic t_grant();
        int f0;
        grant = 1'b0;
        for (int k = 0; k < 300 && !req; k++) @(negedge clk);
        check(req == 1'b1, "R8 request after interval", req, 1);
        f0 = falls;
        repeat (50) @(negedge clk);
        check(req == 1'b1, "R8 request held without grant", req, 1);
        check(falls == f0, "R9 no cycle without grant", falls, f0);
        check(busy == 1'b0, "R12 idle while waiting", busy, 0);
        grant = 1'b1;
        @(negedge clk);
        grant = 1'b0;
        check(cas_n == 1'b0, "R9 cycle starts after grant", cas_n, 0);
        check(busy == 1'b1, "R12 busy at column strobe", busy, 1);
        repeat (12) @(negedge clk);
        check(busy == 1'b0, "R12 busy cleared after precharge", busy, 0);
        check(req == 1'b0, "R8 credit consumed", req, 0);
        check(falls == f0 + 1, "R9 one cycle per grant", falls, f0 + 1);
    endtask

    task automatic t_saturate();
        int f0;
        int n;
        grant = 1'b0;
        repeat (20 * INT_N) @(negedge clk);
        check(req_urgent == 1'b1, "R10 urgent at full queue", req_urgent, 1);
        f0 = falls;
        grant = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 400 && (req || busy); k++) @(negedge clk);
        n = falls - f0;
        check(n >= MAX_PEND() && n <= MAX_PEND() + 1, "R10 saturated drain count", n, MAX_PEND());
        check(req_urgent == 1'b0, "R10 urgent cleared after drain", req_urgent, 0);
    endtask

    function automatic int MAX_PEND();
        return 8;
    endfunction

    task automatic t_interval();
        int f0;
        f0 = falls;
        for (int k = 0; k < 400 && falls < f0 + 2; k++) @(negedge clk);
        check(spacing == INT_N, "R8 refresh spacing with grant held", spacing, INT_N);
        for (int k = 0; k < 4000 && lp_falls < INIT_N + 3; k++) @(negedge clk);
        check(lp_spacing == INT_LP, "R11 low-power refresh spacing", lp_spacing, INT_LP);
    endtask

    task automatic t_waveform();
        check(lead_bad == 0, "R4 column strobe leads row strobe", lead_bad, 0);
        check(overlap_bad == 0, "R5 column low through row low", overlap_bad, 0);
        check(min_low == 6, "R5 row strobe low width", min_low, 6);
        check(min_high >= 4, "R6 row precharge", min_high, 4);
        check(min_f2f >= 11, "R6 row cycle time", min_f2f, 11);
        check(we_bad == 0, "R7 write enable held high", we_bad, 0);
    endtask

    initial begin
        t_reset();
        t_bringup();
        t_grant();
        t_saturate();
        t_interval();
        t_waveform();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100_000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule